// File: doc/BRIEF.md
# Fixed-Point Requantiser with Selectable Rounding and Overflow

This block takes a wide signed fixed-point sample and re-expresses it in a narrower signed format. Both formats are fixed when the block is built. The input format is set by its width and its count of fraction bits. The output format is set by a total word length and an integer word length. The number of output fraction bits is the total length minus the integer length. That count may be negative, or larger than the word itself. When the output has fewer fraction bits than the input, the surplus low bits are dropped and the result is rounded. When it has more, the input is shifted left and no rounding takes place.

Two 3-bit mode inputs are sampled together with each valid sample. One selects how the dropped fraction bits are handled. The other selects what happens when the rounded value does not fit the output range. Rounding is always applied before the range check. One register stage sits between input and output. The output carries the result, a valid strobe, and a flag that is raised whenever the overflow policy changed the value. A build-time count of saturated most-significant bits lets wrap-around mode pin the top bits while the lower bits wrap.

Top module: `fxq_requant`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `out_data` and `out_ovf` become 0 after that edge.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `out_data` and `out_ovf` take a new value only one cycle after a cycle with `in_valid` high, and otherwise keep their value.
- R3: `q_mode` code 0 truncates toward minus infinity (floor). Codes 6 and 7 are unused and behave exactly like code 0.
- R4: `q_mode` code 1 rounds to nearest with ties away from zero. Code 2 rounds to nearest with ties toward zero.
- R5: `q_mode` code 3 truncates toward zero. Code 4 rounds to nearest with ties toward minus infinity.
- R6: `q_mode` code 5 rounds to nearest with ties to the even result.
- R7: The range check is applied to the rounded value. An input that fits only before rounding is treated as out of range.
- R8: `o_mode` code 0 wraps modulo 2^OUT_WL when `NSAT` = 0. Codes 4 to 7 are unused and behave exactly like code 0.
- R9: `o_mode` code 1 clamps out-of-range values to the largest positive or the most negative code.
- R10: `o_mode` code 2 replaces any out-of-range value with 0.
- R11: `o_mode` code 3 clamps to +max or to -max, where -max is the most negative code plus one. An in-range result equal to the most negative code is also moved to -max.
- R12: With `NSAT` > 0 and `o_mode` 0, an out-of-range result gets its top bit set to the sign of the rounded value. The next NSAT-1 bits get the inverse of that sign. The remaining low bits wrap.
- R13: `out_ovf` is 1 exactly when the rounded value did not fit the output format, or when the overflow policy changed the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input, IN_FRAC fraction bits |
| q_mode | input | 3 | Rounding policy code |
| o_mode | input | 3 | Overflow policy code |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | OUT_WL | Signed result, OUT_WL-OUT_IWL fraction bits |
| out_ovf | output | 1 | Overflow policy altered the result |

## Verification
Rounding and overflow handling can act on the same sample. A value just below the positive limit with its dropped half-bit set is rounded up by tie-breaking rounding, and that carries it past the limit. Such inputs are driven under both floor and round-half-away rounding, with saturation and with wrap-around. The results are judged by comparing `out_ovf` and `out_data` across the pair. Floor rounding must leave the largest code with the flag clear. Rounding up must raise the flag and either clamp the result or wrap it to the most negative code.

// File: rtl/fxq_pkg.sv
// Package: shared mode types for the fixed-point requantiser.
// Assumes mode inputs are 3-bit codes; unused codes map to the defaults.
package fxq_pkg;

    typedef enum logic [2:0] {
        QM_FLOOR      = 3'd0,
        QM_HALF_AWAY  = 3'd1,
        QM_HALF_ZERO  = 3'd2,
        QM_CHOP_ZERO  = 3'd3,
        QM_HALF_DOWN  = 3'd4,
        QM_HALF_EVEN  = 3'd5
    } qmode_e;

    typedef enum logic [2:0] {
        OM_WRAP       = 3'd0,
        OM_CLAMP      = 3'd1,
        OM_CLAMP_ZERO = 3'd2,
        OM_CLAMP_SYM  = 3'd3
    } omode_e;

    // Map a raw rounding code to its policy, unused codes to floor.
    function automatic qmode_e decode_qmode(input logic [2:0] code);
        case (code)
            3'd1:    return QM_HALF_AWAY;
            3'd2:    return QM_HALF_ZERO;
            3'd3:    return QM_CHOP_ZERO;
            3'd4:    return QM_HALF_DOWN;
            3'd5:    return QM_HALF_EVEN;
            default: return QM_FLOOR;
        endcase
    endfunction

    // Map a raw overflow code to its policy, unused codes to wrap.
    function automatic omode_e decode_omode(input logic [2:0] code);
        case (code)
            3'd1:    return OM_CLAMP;
            3'd2:    return OM_CLAMP_ZERO;
            3'd3:    return OM_CLAMP_SYM;
            default: return OM_WRAP;
        endcase
    endfunction

endpackage

// File: rtl/fxq_quant.sv
// Module: fxq_quant
// Re-aligns a signed value by SHIFT fraction bits. When SHIFT > 0 the low
// SHIFT bits are dropped and the kept part is incremented according to the
// rounding policy. One extra result bit absorbs the carry. When SHIFT <= 0
// the value is shifted left and no rounding applies.
// Assumes SHIFT < IN_W. Purely combinational.
module fxq_quant
    import fxq_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int SHIFT = 4,
    parameter int Q_W   = (SHIFT > 0) ? IN_W - SHIFT + 1 : IN_W - SHIFT
) (
    input  logic signed [IN_W-1:0] din,
    input  qmode_e                 mode,
    output logic signed [Q_W-1:0]  dout
);

    generate
        if (SHIFT > 0) begin : g_drop
            localparam logic [SHIFT-1:0] LOW_MASK = {SHIFT{1'b1}} >> 1;

            logic signed [Q_W-1:0] kept;
            logic [SHIFT-1:0]      tail;
            logic                  half_bit;
            logic                  below_half;
            logic                  any_tail;
            logic                  neg;
            logic                  bump;

            // Split the input into the kept floor value and the dropped tail.
            always_comb begin
                kept       = $signed({din[IN_W-1], din[IN_W-1:SHIFT]});
                tail       = din[SHIFT-1:0];
                half_bit   = tail[SHIFT-1];
                below_half = |(tail & LOW_MASK);
                any_tail   = |tail;
                neg        = din[IN_W-1];
            end

            // Decide whether the floor value is moved up by one LSB.
            always_comb begin
                case (mode)
                    QM_HALF_AWAY: bump = half_bit & (~neg | below_half);
                    QM_HALF_ZERO: bump = half_bit & (neg | below_half);
                    QM_CHOP_ZERO: bump = neg & any_tail;
                    QM_HALF_DOWN: bump = half_bit & below_half;
                    QM_HALF_EVEN: bump = half_bit & (below_half | kept[0]);
                    default:      bump = 1'b0;
                endcase
            end

            // Apply the increment in the widened result.
            assign dout = kept + $signed({{(Q_W-1){1'b0}}, bump});
        end else if (SHIFT == 0) begin : g_same
            assign dout = din;
        end else begin : g_grow
            assign dout = $signed({din, {(-SHIFT){1'b0}}});
        end
    endgenerate

endmodule

// File: rtl/fxq_ovf.sv
// Module: fxq_ovf
// Fits a rounded signed value of E_W bits into OUT_WL bits under the chosen
// overflow policy, and reports whether the policy altered the value.
// Assumes E_W > OUT_WL and 0 <= NSAT <= OUT_WL. Purely combinational.
module fxq_ovf
    import fxq_pkg::*;
#(
    parameter int E_W    = 14,
    parameter int OUT_WL = 8,
    parameter int NSAT   = 0
) (
    input  logic signed [E_W-1:0]  din,
    input  omode_e                 mode,
    output logic [OUT_WL-1:0]      dout,
    output logic                   ovf
);

    localparam logic [OUT_WL-1:0] POS_MAX = {1'b0, {(OUT_WL-1){1'b1}}};
    localparam logic [OUT_WL-1:0] NEG_MIN = {1'b1, {(OUT_WL-1){1'b0}}};
    localparam logic [OUT_WL-1:0] NEG_SYM = NEG_MIN | OUT_WL'(1);
    localparam int HEAD_W = E_W - OUT_WL + 1;

    logic [HEAD_W-1:0] head;
    logic              fits;
    logic              sgn;
    logic [OUT_WL-1:0] low;
    logic [OUT_WL-1:0] wrapped;

    // The value fits when every bit from the output sign bit up is equal.
    always_comb begin
        head = din[E_W-1:OUT_WL-1];
        fits = (&head) | ~(|head);
        sgn  = din[E_W-1];
        low  = din[OUT_WL-1:0];
    end

    generate
        if (NSAT == 0) begin : g_plain_wrap
            assign wrapped = low;
        end else begin : g_part_sat
            // Pin the top NSAT bits to the saturated pattern, keep the rest.
            always_comb begin
                for (int i = 0; i < OUT_WL; i++) begin
                    if (fits)                     wrapped[i] = low[i];
                    else if (i == OUT_WL - 1)     wrapped[i] = sgn;
                    else if (i >= OUT_WL - NSAT)  wrapped[i] = ~sgn;
                    else                          wrapped[i] = low[i];
                end
            end
        end
    endgenerate

    // Select the result according to the overflow policy.
    always_comb begin
        case (mode)
            OM_CLAMP:      dout = fits ? low : (sgn ? NEG_MIN : POS_MAX);
            OM_CLAMP_ZERO: dout = fits ? low : '0;
            OM_CLAMP_SYM:  dout = !fits ? (sgn ? NEG_SYM : POS_MAX)
                                        : ((low == NEG_MIN) ? NEG_SYM : low);
            default:       dout = wrapped;
        endcase
    end

    // Flag any case where the delivered value differs from the rounded one.
    assign ovf = !fits || (dout != low);

endmodule

// File: rtl/fxq_requant.sv
// Module: fxq_requant (top)
// Converts a signed input with IN_FRAC fraction bits to a signed OUT_WL-bit
// word with OUT_IWL integer bits. Rounding comes first, then the range
// policy. One register stage sits between input and output. Uses a
// synchronous active-low reset.
// Assumes OUT_WL >= 2, IN_FRAC - (OUT_WL - OUT_IWL) < IN_W, NSAT <= OUT_WL.
module fxq_requant
    import fxq_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int IN_FRAC = 8,
    parameter int OUT_WL  = 8,
    parameter int OUT_IWL = 4,
    parameter int NSAT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    input  logic [2:0]        q_mode,
    input  logic [2:0]        o_mode,
    output logic              out_valid,
    output logic [OUT_WL-1:0] out_data,
    output logic              out_ovf
);

    localparam int OUT_FRAC = OUT_WL - OUT_IWL;
    localparam int SHIFT    = IN_FRAC - OUT_FRAC;
    localparam int Q_W      = (SHIFT > 0) ? IN_W - SHIFT + 1 : IN_W - SHIFT;
    localparam int E_W      = ((Q_W > OUT_WL) ? Q_W : OUT_WL) + 1;
    localparam logic [OUT_WL-1:0] POS_MAX = {1'b0, {(OUT_WL-1){1'b1}}};
    localparam logic [OUT_WL-1:0] NEG_MIN = {1'b1, {(OUT_WL-1){1'b0}}};

    qmode_e                qm;
    omode_e                om;
    logic signed [Q_W-1:0] q_val;
    logic signed [E_W-1:0] q_ext;
    logic [OUT_WL-1:0]     fit_val;
    logic                  fit_ovf;

    // Decode raw mode codes, unused ones fall back to the defaults.
    assign qm = decode_qmode(q_mode);
    assign om = decode_omode(o_mode);

    fxq_quant #(
        .IN_W  (IN_W),
        .SHIFT (SHIFT),
        .Q_W   (Q_W)
    ) u_quant (
        .din  ($signed(in_data)),
        .mode (qm),
        .dout (q_val)
    );

    // Sign-extend the rounded value so the range check always has headroom.
    assign q_ext = E_W'(q_val);

    fxq_ovf #(
        .E_W    (E_W),
        .OUT_WL (OUT_WL),
        .NSAT   (NSAT)
    ) u_ovf (
        .din  (q_ext),
        .mode (om),
        .dout (fit_val),
        .ovf  (fit_ovf)
    );

    // Output stage: strobe always follows, data loads only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ovf   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= fit_val;
                out_ovf  <= fit_ovf;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_valid == $past(in_valid)));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_valid) |=> ($stable(out_data) && $stable(out_ovf)));

    // R9
    clamp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && o_mode == 3'd1) |=>
            (!out_ovf || out_data == POS_MAX || out_data == NEG_MIN));

    // R10
    clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && o_mode == 3'd2) |=> (!out_ovf || out_data == '0));

    // R11
    sym_no_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && o_mode == 3'd3) |=> (out_data != NEG_MIN));

endmodule

// File: tb/fxq_requant_tb.sv
`timescale 1ns/1ps
module fxq_requant_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [2:0]  q_mode = '0;
    logic [2:0]  o_mode = '0;
    logic        out_valid, ps_valid;
    logic [7:0]  out_data, ps_data;
    logic        out_ovf, ps_ovf;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fxq_requant u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .q_mode(q_mode), .o_mode(o_mode),
        .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
    );

    fxq_requant #(.NSAT(2)) u_dut_nsat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .q_mode(q_mode), .o_mode(o_mode),
        .out_valid(ps_valid), .out_data(ps_data), .out_ovf(ps_ovf)
    );

    // Input Q8.8 (16 bits), output Q4.4 (8 bits); 4 fraction bits dropped.
    // Fields: q_mode[30:28] o_mode[27:25] in[24:9] out[8:1] ovf[0]
    localparam int NV = 33;
    localparam logic [30:0] VEC [NV] = '{
        {3'd0, 3'd0, 16'h0123, 8'h12, 1'b0},  // R3 floor positive
        {3'd0, 3'd0, 16'hFEDD, 8'hED, 1'b0},  // R3 floor negative
        {3'd6, 3'd0, 16'hFEDD, 8'hED, 1'b0},  // R3 unused code 6
        {3'd7, 3'd0, 16'h0128, 8'h12, 1'b0},  // R3 unused code 7
        {3'd1, 3'd0, 16'h0128, 8'h13, 1'b0},  // R4 tie away, +
        {3'd1, 3'd0, 16'hFED8, 8'hED, 1'b0},  // R4 tie away, -
        {3'd2, 3'd0, 16'h0128, 8'h12, 1'b0},  // R4 tie to zero, +
        {3'd2, 3'd0, 16'hFED8, 8'hEE, 1'b0},  // R4 tie to zero, -
        {3'd1, 3'd0, 16'h0127, 8'h12, 1'b0},  // R4 below half
        {3'd3, 3'd0, 16'hFEDD, 8'hEE, 1'b0},  // R5 chop toward zero, -
        {3'd3, 3'd0, 16'h012F, 8'h12, 1'b0},  // R5 chop toward zero, +
        {3'd4, 3'd0, 16'h0128, 8'h12, 1'b0},  // R5 tie down, +
        {3'd4, 3'd0, 16'hFED8, 8'hED, 1'b0},  // R5 tie down, -
        {3'd4, 3'd0, 16'h0129, 8'h13, 1'b0},  // R5 above half
        {3'd5, 3'd0, 16'h0128, 8'h12, 1'b0},  // R6 tie to even 18
        {3'd5, 3'd0, 16'h0138, 8'h14, 1'b0},  // R6 tie to even 20
        {3'd5, 3'd0, 16'hFEC8, 8'hEC, 1'b0},  // R6 tie to even -20
        {3'd5, 3'd0, 16'h0139, 8'h14, 1'b0},  // R6 above half
        {3'd1, 3'd1, 16'h07F8, 8'h7F, 1'b1},  // R7 rounding pushes out, clamp
        {3'd0, 3'd1, 16'h07F8, 8'h7F, 1'b0},  // R7 floor stays in range
        {3'd1, 3'd0, 16'h07F8, 8'h80, 1'b1},  // R7 rounding pushes out, wrap
        {3'd0, 3'd0, 16'h0900, 8'h90, 1'b1},  // R8 wrap positive
        {3'd0, 3'd5, 16'h0900, 8'h90, 1'b1},  // R8 unused code 5
        {3'd0, 3'd0, 16'hF700, 8'h70, 1'b1},  // R8 wrap negative
        {3'd0, 3'd1, 16'h0900, 8'h7F, 1'b1},  // R9 clamp high
        {3'd0, 3'd1, 16'hF700, 8'h80, 1'b1},  // R9 clamp low
        {3'd0, 3'd1, 16'hF800, 8'h80, 1'b0},  // R9 exact minimum
        {3'd0, 3'd2, 16'h0900, 8'h00, 1'b1},  // R10 zeroed
        {3'd0, 3'd2, 16'h0500, 8'h50, 1'b0},  // R10 in range
        {3'd0, 3'd3, 16'hF700, 8'h81, 1'b1},  // R11 sym low
        {3'd0, 3'd3, 16'hF800, 8'h81, 1'b1},  // R11 minimum code moved
        {3'd0, 3'd3, 16'h0900, 8'h7F, 1'b1},  // R11 sym high
        {3'd0, 3'd3, 16'hF810, 8'h81, 1'b0}   // R11 -max in range
    };

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one sample at a falling edge; outputs are sampled one cycle later.
    task automatic apply(input logic [2:0] q, input logic [2:0] o,
                         input logic [15:0] d);
        @(negedge clk);
        q_mode = q; o_mode = o; in_data = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 valid", 16'(out_valid), 16'd0);
        check("R1 data",  16'(out_data),  16'd0);
        check("R1 ovf",   16'(out_ovf),   16'd0);
        rst_n = 1'b1;

        // Table walk: rounding, overflow and the flag (R13) on each entry
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][30:28], VEC[i][27:25], VEC[i][24:9]);
            check($sformatf("R2 valid vec %0d", i), 16'(out_valid), 16'd1);
            check($sformatf("vec %0d data", i), 16'(out_data), 16'(VEC[i][8:1]));
            check($sformatf("R13 vec %0d ovf", i), 16'(out_ovf), 16'(VEC[i][0]));
        end

        // R2 no valid input: strobe drops and result holds
        @(negedge clk);
        in_data = 16'h0330; q_mode = 3'd0; o_mode = 3'd0;
        @(negedge clk);
        check("R2 valid low", 16'(out_valid), 16'd0);
        check("R2 data held", 16'(out_data), 16'h81);
        check("R2 ovf held",  16'(out_ovf),  16'd0);

        // R12 partial saturation of two bits in wrap mode
        apply(3'd0, 3'd0, 16'h0900);
        check("R12 pos data", 16'(ps_data), 16'h50);
        check("R12 pos ovf",  16'(ps_ovf),  16'd1);
        apply(3'd0, 3'd0, 16'hF700);
        check("R12 neg data", 16'(ps_data), 16'hB0);
        check("R12 neg ovf",  16'(ps_ovf),  16'd1);
        apply(3'd0, 3'd0, 16'h0330);
        check("R12 in range", 16'(ps_data), 16'h33);
        check("R12 no ovf",   16'(ps_ovf),  16'd0);
        apply(3'd0, 3'd1, 16'h0900);
        check("R12 clamp unaffected", 16'(ps_data), 16'h7F);

        // R1 reset in mid-run clears the registered result
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R1 mid valid", 16'(out_valid), 16'd0);
        check("R1 mid data",  16'(out_data),  16'd0);
        check("R1 mid ovf",   16'(out_ovf),   16'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule